// File: doc/BRIEF.md
# Banked Address Translator

This block turns every 16-bit bus address into the upper address byte sent to memory, a pair of active-low bank strobes and four memory-select lines. It is purely combinational. It reads its settings from register outputs that a separate configuration block holds. A cycle-type input tells it whether the processor or the video fetch unit owns the bus. Video fetches are always sent to a fixed 4 KB window in the bank the video setting names.

Processor cycles go through several stages. There is a small register window that must reach the configuration block and not memory. An overlay maps a boot ROM under the low 4 KB while the second processor runs. Page 0 and page 1 can each be moved to any page of either bank, and an access to a moved-to page is swapped back to the physical page 0 or 1. Each of the three upper 16 KB regions can select ROM or RAM. Finally, a shared-RAM area at the top or bottom of the map pins accesses to bank 0. In legacy mode all of the processor mapping is bypassed.

Top module: `bank_xlate`

## Requirements
- R1: When `cpu_cycle_i` is 0 the cycle is a video fetch. `xaddr_hi_o` is {4'hF, addr_i[11:8]}, the bank is `vid_bank_i`, and `msel_o[1:0]` is 2'b11. This holds whether or not legacy mode is on.
- R2: By default a processor cycle passes `addr_i[15:8]` to `xaddr_hi_o` and takes the bank from `map_cfg_i[6]`. The strobes encode bank b as `bank_n_o` = {~b, b}: bank 0 gives 2'b10 and bank 1 gives 2'b01. They are complementary on every cycle except those covered by R4.
- R3: `msel_o[2]` always equals `map_cfg_i[0]` and `msel_o[3]` always equals `~legacy_i`. `msel_o[1:0]` = 2'b11 means RAM.
- R4: A processor cycle outside legacy mode to an address from 0xFF00 to 0xFF04 drives `bank_n_o` = 2'b11 and leaves `msel_o[1:0]` = 2'b11. Address 0xFF05 is mapped normally.
- R5: A processor cycle outside legacy mode, with `alt_cpu_i` = 1, `map_cfg_i[6]` = 0 and an address below 0x1000, gives `xaddr_hi_o` = {4'hD, addr_i[11:8]} and `msel_o[1:0]` = 2'b00. Address 0x1000, or bank bit 1, is mapped normally.
- R6: Outside legacy mode, addresses 0x0000–0x00FF produce `xaddr_hi_o` = `pg0_ptr_i` with bank `pg0_bank_i`. Addresses 0x0100–0x01FF produce `pg1_ptr_i` with bank `pg1_bank_i`.
- R7: Outside legacy mode, `msel_o[1:0]` is set by address range. For 0x4000–0x7FFF both bits equal `map_cfg_i[1]`. For 0x8000–0xBFFF the pair is {map_cfg_i[3], map_cfg_i[2]}. For 0xC000–0xFFFF it is {map_cfg_i[5], map_cfg_i[4]}. Below 0x4000 it is 2'b11.
- R8: Outside legacy mode, when `msel_o[1:0]` = 2'b11, the swap-back rule applies. If `addr_i[15:8]` equals `pg0_ptr_i`, `xaddr_hi_o` becomes 0x00. Otherwise, if it equals `pg1_ptr_i`, `xaddr_hi_o` becomes 0x01. When `msel_o[1:0]` is not 2'b11, the upper byte is untouched.
- R9: `share_size_i` selects the shared size: 0→1 KB, 1→4 KB, 2→8 KB, 3→16 KB. Outside legacy mode the bank is forced to 0 in two cases. The first is `share_lo_en_i` with an address below the size. The second is `share_hi_en_i` with an address at or above 0x10000 minus the size.
- R10: In legacy mode a processor cycle ignores the register window, overlay, relocation, ROM selection and sharing. `xaddr_hi_o` is `addr_i[15:8]`, the bank is `map_cfg_i[6]`, and `msel_o[1:0]` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Bus address |
| cpu_cycle_i | input | 1 | 1 = processor cycle, 0 = video fetch |
| legacy_i | input | 1 | Legacy mapping mode |
| alt_cpu_i | input | 1 | Second processor owns the bus |
| map_cfg_i | input | 7 | [0] I/O select, [1] low ROM, [3:2] mid ROM, [5:4] high ROM, [6] processor bank |
| vid_bank_i | input | 1 | Bank for video fetches |
| share_size_i | input | 2 | Shared RAM size code |
| share_lo_en_i | input | 1 | Share bottom of the map |
| share_hi_en_i | input | 1 | Share top of the map |
| pg0_ptr_i | input | 8 | Target page for page 0 |
| pg0_bank_i | input | 1 | Target bank for page 0 |
| pg1_ptr_i | input | 8 | Target page for page 1 |
| pg1_bank_i | input | 1 | Target bank for page 1 |
| xaddr_hi_o | output | 8 | Translated upper address byte |
| bank_n_o | output | 2 | Active-low bank strobes, [0] bank 0, [1] bank 1 |
| msel_o | output | 4 | Memory selects |

## Verification
The block holds no state, so a wrong internal decision shows at the ports in the same cycle the address is applied. The symptoms depend on where the fault sits. A broken region decode shows up as a wrong `msel_o[1:0]` pattern. A bad pointer comparison sends a page to the wrong upper byte. A misplaced share threshold flips one strobe pair right at a size boundary. The vectors are therefore placed on the exact edges of each window: 0xFF04/0xFF05, 0x0FFF/0x1000, 0x03FF/0x0400, 0xBFFF/0xC000 and 0xDFFF/0xE000. This lets an off-by-one in any comparator appear on a single vector.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

   // processor-side configuration byte, bit positions fixed by the register block
   typedef struct packed {
      logic       bank;
      logic [1:0] rom_hi;
      logic [1:0] rom_mid;
      logic       rom_lo;
      logic       io_sel;
   } map_cfg_t;

   // 16 KB region index taken from the two top address bits
   typedef enum logic [1:0] {
      RGN_BASE = 2'd0,
      RGN_LO   = 2'd1,
      RGN_MID  = 2'd2,
      RGN_HI   = 2'd3
   } region_e;

   // shared area size in bytes: 1K, 4K, 8K, 16K
   function automatic logic [16:0] share_span(input logic [1:0] code);
      logic [4:0] sh;
      sh = (code == 2'd0) ? 5'd10 : 5'd11 + {3'd0, code};
      return 17'd1 << sh;
   endfunction

endpackage

// File: rtl/xlate_rom_sel.sv
module xlate_rom_sel
   import xlate_pkg::*;
(
   input  logic [1:0] region_i,
   input  map_cfg_t   cfg_i,
   output logic [1:0] msel_o
);

   region_e rgn;

   always_comb begin
      rgn = region_e'(region_i);
      unique case (rgn)
         RGN_LO:  msel_o = {2{cfg_i.rom_lo}};
         RGN_MID: msel_o = {cfg_i.rom_mid[1], cfg_i.rom_mid[0]};
         RGN_HI:  msel_o = {cfg_i.rom_hi[1], cfg_i.rom_hi[0]};
         default: msel_o = 2'b11;
      endcase
   end

endmodule

// File: rtl/xlate_page_map.sv
module xlate_page_map #(
   parameter int PAGE_W = 8,
   parameter int N_PTR  = 2
) (
   input  logic [PAGE_W-1:0] page_i,
   input  logic [PAGE_W-1:0] ptr_i  [N_PTR],
   input  logic              bank_i [N_PTR],
   output logic              redir_o,
   output logic [PAGE_W-1:0] redir_page_o,
   output logic              redir_bank_o,
   output logic              swap_o,
   output logic [PAGE_W-1:0] swap_page_o
);

   localparam int IDX_W = (N_PTR > 1) ? $clog2(N_PTR) : 1;

   logic [N_PTR-1:0] hit;
   logic [N_PTR-1:0] own;

   generate
      for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
         assign own[g] = (page_i == PAGE_W'(g));
         assign hit[g] = (page_i == ptr_i[g]);
      end
   endgenerate

   always_comb begin
      redir_o      = |own;
      redir_page_o = page_i;
      redir_bank_o = 1'b0;
      for (int k = N_PTR - 1; k >= 0; k--) begin
         if (own[k]) begin
            redir_page_o = ptr_i[k];
            redir_bank_o = bank_i[k];
         end
      end
   end

   // lowest-numbered matching pointer wins
   always_comb begin
      logic [IDX_W-1:0] idx;
      idx  = '0;
      for (int k = N_PTR - 1; k >= 0; k--) begin
         if (hit[k]) idx = IDX_W'(k);
      end
      swap_o      = |hit;
      swap_page_o = PAGE_W'(idx);
   end

endmodule

// File: rtl/xlate_share.sv
module xlate_share
   import xlate_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter bit MAG_CMP   = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        size_i,
   input  logic              lo_en_i,
   input  logic              hi_en_i,
   output logic              force0_o
);

   localparam logic [ADDR_W:0] FULL = {1'b1, {ADDR_W{1'b0}}};

   logic [ADDR_W:0] span;
   logic            in_lo;
   logic            in_hi;

   assign span = share_span(size_i);

   generate
      if (MAG_CMP) begin : g_mag
         assign in_lo = ({1'b0, addr_i} <  span);
         assign in_hi = ({1'b0, addr_i} >= (FULL - span));
      end else begin : g_mask
         logic [ADDR_W-1:0] keep;
         assign keep  = ~(span[ADDR_W-1:0] - 1'b1);
         assign in_lo = ((addr_i & keep) == '0);
         assign in_hi = ((addr_i & keep) == keep);
      end
   endgenerate

   assign force0_o = (lo_en_i & in_lo) | (hi_en_i & in_hi);

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
   import xlate_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter int          PAGE_W      = 8,
   parameter logic [15:0] WIN_BASE    = 16'hFF00,
   parameter int          WIN_COUNT   = 5,
   parameter logic [7:0]  BOOT_LIMIT  = 8'h10,
   parameter logic [3:0]  BOOT_NIB    = 4'hD,
   parameter logic [3:0]  VID_NIB     = 4'hF,
   parameter bit          SHARE_MAG   = 1'b1
) (
   input  logic [15:0] addr_i,
   input  logic        cpu_cycle_i,
   input  logic        legacy_i,
   input  logic        alt_cpu_i,
   input  logic [6:0]  map_cfg_i,
   input  logic        vid_bank_i,
   input  logic [1:0]  share_size_i,
   input  logic        share_lo_en_i,
   input  logic        share_hi_en_i,
   input  logic [7:0]  pg0_ptr_i,
   input  logic        pg0_bank_i,
   input  logic [7:0]  pg1_ptr_i,
   input  logic        pg1_bank_i,
   output logic [7:0]  xaddr_hi_o,
   output logic [1:0]  bank_n_o,
   output logic [3:0]  msel_o
);

   localparam int OFF_W  = ADDR_W - PAGE_W;
   localparam int NIB_LO = OFF_W;
   localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + (ADDR_W+1)'(WIN_COUNT);

   generate
      if (ADDR_W != 16 || PAGE_W != 8) begin : g_bad_geom
         $error("bank_xlate: only a 16-bit bus with 8-bit pages is supported");
      end
      if (WIN_COUNT < 1 || WIN_COUNT > 256) begin : g_bad_win
         $error("bank_xlate: register window size out of range");
      end
      if (BOOT_LIMIT == 8'h00 || BOOT_LIMIT > 8'h10) begin : g_bad_boot
         $error("bank_xlate: boot overlay must lie within the first 4 KB");
      end
   endgenerate

   map_cfg_t          cfg;
   logic [PAGE_W-1:0] page;
   logic [3:0]        sub_nib;
   logic [1:0]        rom_ms;
   logic              redir;
   logic [PAGE_W-1:0] redir_page;
   logic              redir_bank;
   logic              swap;
   logic [PAGE_W-1:0] swap_page;
   logic              force0;
   logic              in_win;
   logic              in_boot;
   logic [PAGE_W-1:0] ptrs  [2];
   logic              banks [2];

   assign cfg     = map_cfg_t'(map_cfg_i);
   assign page    = addr_i[ADDR_W-1:OFF_W];
   assign sub_nib = addr_i[NIB_LO+3:NIB_LO];
   assign ptrs[0]  = pg0_ptr_i;
   assign ptrs[1]  = pg1_ptr_i;
   assign banks[0] = pg0_bank_i;
   assign banks[1] = pg1_bank_i;

   assign in_win  = ({1'b0, addr_i} >= {1'b0, WIN_BASE}) && ({1'b0, addr_i} < WIN_END);
   assign in_boot = alt_cpu_i && !cfg.bank && (page < BOOT_LIMIT);

   xlate_rom_sel u_rom (
      .region_i (addr_i[ADDR_W-1:ADDR_W-2]),
      .cfg_i    (cfg),
      .msel_o   (rom_ms)
   );

   xlate_page_map #(.PAGE_W(PAGE_W), .N_PTR(2)) u_pages (
      .page_i       (page),
      .ptr_i        (ptrs),
      .bank_i       (banks),
      .redir_o      (redir),
      .redir_page_o (redir_page),
      .redir_bank_o (redir_bank),
      .swap_o       (swap),
      .swap_page_o  (swap_page)
   );

   xlate_share #(.ADDR_W(ADDR_W), .MAG_CMP(SHARE_MAG)) u_share (
      .addr_i   (addr_i),
      .size_i   (share_size_i),
      .lo_en_i  (share_lo_en_i),
      .hi_en_i  (share_hi_en_i),
      .force0_o (force0)
   );

   logic       bank;
   logic       both_off;
   logic [1:0] ms_low;

   always_comb begin
      xaddr_hi_o = page;
      bank       = cfg.bank;
      both_off   = 1'b0;
      ms_low     = 2'b11;
      if (!cpu_cycle_i) begin
         xaddr_hi_o = {VID_NIB, sub_nib};
         bank       = vid_bank_i;
      end else if (!legacy_i) begin
         if (in_win) begin
            both_off = 1'b1;
         end else if (in_boot) begin
            xaddr_hi_o = {BOOT_NIB, sub_nib};
            ms_low     = 2'b00;
         end else begin
            if (redir) begin
               xaddr_hi_o = redir_page;
               bank       = redir_bank;
            end else begin
               ms_low = rom_ms;
            end
            if (ms_low == 2'b11 && swap) xaddr_hi_o = swap_page;
            if (force0) bank = 1'b0;
         end
      end
   end

   assign bank_n_o = both_off ? 2'b11 : {~bank, bank};
   assign msel_o   = {~legacy_i, cfg.io_sel, ms_low};

endmodule

// File: rtl/xlate_chk.sv
module xlate_chk (
   input logic [15:0] addr_i,
   input logic        cpu_cycle_i,
   input logic        legacy_i,
   input logic        alt_cpu_i,
   input logic [6:0]  map_cfg_i,
   input logic        vid_bank_i,
   input logic        share_lo_en_i,
   input logic [7:0]  xaddr_hi_o,
   input logic [1:0]  bank_n_o,
   input logic [3:0]  msel_o
);

   logic win;
   logic native;
   assign win    = (addr_i >= 16'hFF00) && (addr_i <= 16'hFF04);
   assign native = cpu_cycle_i && !legacy_i;

   always_comb begin
      if (!cpu_cycle_i) begin
         AST_VID_WINDOW: assert (xaddr_hi_o == {4'hF, addr_i[11:8]} && bank_n_o == {~vid_bank_i, vid_bank_i}) else $error("video map"); // R1
      end
      if (!(native && win)) begin
         AST_STROBE_COMPL: assert (bank_n_o[0] != bank_n_o[1]) else $error("strobes not complementary"); // R2
      end
      AST_SEL_FIXED: assert (msel_o[3] == !legacy_i && msel_o[2] == map_cfg_i[0]) else $error("fixed selects"); // R3
      if (native && win) begin
         AST_REG_WINDOW: assert (bank_n_o == 2'b11 && msel_o[1:0] == 2'b11) else $error("register window"); // R4
      end
      if (native && alt_cpu_i && !map_cfg_i[6] && addr_i < 16'h1000) begin
         AST_BOOT_OVERLAY: assert (msel_o[1:0] == 2'b00 && xaddr_hi_o[7:4] == 4'hD) else $error("boot overlay"); // R5
      end
      if (cpu_cycle_i && legacy_i) begin
         AST_LEGACY_PASS: assert (xaddr_hi_o == addr_i[15:8] && msel_o[1:0] == 2'b11) else $error("legacy pass"); // R10
      end
      if (native && share_lo_en_i && addr_i < 16'h0400 && !(alt_cpu_i && !map_cfg_i[6])) begin
         AST_SHARE_LOW: assert (bank_n_o == 2'b10) else $error("bottom share"); // R9
      end
   end

endmodule

bind bank_xlate xlate_chk u_chk (
   .addr_i        (addr_i),
   .cpu_cycle_i   (cpu_cycle_i),
   .legacy_i      (legacy_i),
   .alt_cpu_i     (alt_cpu_i),
   .map_cfg_i     (map_cfg_i),
   .vid_bank_i    (vid_bank_i),
   .share_lo_en_i (share_lo_en_i),
   .xaddr_hi_o    (xaddr_hi_o),
   .bank_n_o      (bank_n_o),
   .msel_o        (msel_o)
);

// File: tb/tb_bank_xlate.sv
`timescale 1ns/1ps
module tb_bank_xlate;

   typedef struct packed {
      logic [3:0]  req;
      logic        cpu, leg, alt;
      logic [6:0]  cfg;
      logic        vb;
      logic [1:0]  ssz;
      logic        slo, shi;
      logic [7:0]  p0;
      logic        p0b;
      logic [7:0]  p1;
      logic        p1b;
      logic [15:0] addr;
      logic [7:0]  ta;
      logic [1:0]  bn;
      logic [3:0]  ms;
   } vec_t;

   localparam int NV = 21;
   // req, cpu,leg,alt, cfg, vb, ssz,slo,shi, p0,p0b, p1,p1b, addr, ta, bn, ms
   localparam vec_t VECS [NV] = '{
      '{4'd2, 1,0,0, 7'h00, 0, 2'd0,0,0, 8'h00,0, 8'h01,0, 16'h1234, 8'h12, 2'b10, 4'b1011}, // R2
      '{4'd2, 1,0,0, 7'h40, 0, 2'd0,0,0, 8'h00,0, 8'h01,0, 16'h1234, 8'h12, 2'b01, 4'b1011}, // R2
      '{4'd7, 1,0,0, 7'h00, 0, 2'd0,0,0, 8'h00,0, 8'h01,0, 16'h4000, 8'h40, 2'b10, 4'b1000}, // R7
      '{4'd7, 1,0,0, 7'h04, 0, 2'd0,0,0, 8'h00,0, 8'h01,0, 16'h9ABC, 8'h9A, 2'b10, 4'b1001}, // R7
      '{4'd3, 1,0,0, 7'h21, 0, 2'd0,0,0, 8'h00,0, 8'h01,0, 16'hE000, 8'hE0, 2'b10, 4'b1110}, // R3
      '{4'd4, 1,0,0, 7'h00, 0, 2'd0,0,0, 8'h00,0, 8'h01,0, 16'hFF02, 8'hFF, 2'b11, 4'b1011}, // R4
      '{4'd4, 1,0,0, 7'h00, 0, 2'd0,0,0, 8'h00,0, 8'h01,0, 16'hFF05, 8'hFF, 2'b10, 4'b1000}, // R4
      '{4'd5, 1,0,1, 7'h00, 0, 2'd0,0,0, 8'h00,0, 8'h01,0, 16'h0ABC, 8'hDA, 2'b10, 4'b1000}, // R5
      '{4'd5, 1,0,1, 7'h40, 0, 2'd0,0,0, 8'h00,0, 8'h01,0, 16'h0ABC, 8'h0A, 2'b01, 4'b1011}, // R5
      '{4'd6, 1,0,0, 7'h00, 0, 2'd0,0,0, 8'h37,1, 8'h01,0, 16'h0042, 8'h37, 2'b01, 4'b1011}, // R6
      '{4'd6, 1,0,0, 7'h40, 0, 2'd0,0,0, 8'h00,0, 8'h80,0, 16'h01FF, 8'h80, 2'b10, 4'b1011}, // R6
      '{4'd8, 1,0,0, 7'h00, 0, 2'd0,0,0, 8'h37,0, 8'h01,0, 16'h3710, 8'h00, 2'b10, 4'b1011}, // R8
      '{4'd8, 1,0,0, 7'h02, 0, 2'd0,0,0, 8'h00,0, 8'h45,0, 16'h45AA, 8'h01, 2'b10, 4'b1011}, // R8
      '{4'd8, 1,0,0, 7'h00, 0, 2'd0,0,0, 8'h50,0, 8'h01,0, 16'h5000, 8'h50, 2'b10, 4'b1000}, // R8
      '{4'd9, 1,0,0, 7'h40, 0, 2'd0,1,0, 8'h00,0, 8'h01,0, 16'h03FF, 8'h03, 2'b10, 4'b1011}, // R9
      '{4'd9, 1,0,0, 7'h40, 0, 2'd0,1,0, 8'h00,0, 8'h01,0, 16'h0400, 8'h04, 2'b01, 4'b1011}, // R9
      '{4'd9, 1,0,0, 7'h40, 0, 2'd3,0,1, 8'h00,0, 8'h01,0, 16'hC000, 8'hC0, 2'b10, 4'b1000}, // R9
      '{4'd9, 1,0,0, 7'h40, 0, 2'd3,0,1, 8'h00,0, 8'h01,0, 16'hBFFF, 8'hBF, 2'b01, 4'b1000}, // R9
      '{4'd1, 0,0,0, 7'h01, 1, 2'd0,0,0, 8'h00,0, 8'h01,0, 16'h1234, 8'hF2, 2'b01, 4'b1111}, // R1
      '{4'd10,1,1,0, 7'h40, 0, 2'd0,0,0, 8'h00,0, 8'h01,0, 16'hFF02, 8'hFF, 2'b01, 4'b0011}, // R10
      '{4'd10,1,1,0, 7'h00, 0, 2'd0,0,0, 8'h37,0, 8'h01,0, 16'h0010, 8'h00, 2'b10, 4'b0011}  // R10
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [15:0] addr_i = '0;
   logic        cpu_cycle_i = 1'b0, legacy_i = 1'b0, alt_cpu_i = 1'b0;
   logic [6:0]  map_cfg_i = '0;
   logic        vid_bank_i = 1'b0;
   logic [1:0]  share_size_i = '0;
   logic        share_lo_en_i = 1'b0, share_hi_en_i = 1'b0;
   logic [7:0]  pg0_ptr_i = '0, pg1_ptr_i = 8'h01;
   logic        pg0_bank_i = 1'b0, pg1_bank_i = 1'b0;
   logic [7:0]  xaddr_hi_o;
   logic [1:0]  bank_n_o;
   logic [3:0]  msel_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   bank_xlate dut (.*);

   task automatic run_vec(input vec_t v, input string tag);
      @(negedge clk);
      cpu_cycle_i   = v.cpu;  legacy_i      = v.leg;  alt_cpu_i  = v.alt;
      map_cfg_i     = v.cfg;  vid_bank_i    = v.vb;   share_size_i = v.ssz;
      share_lo_en_i = v.slo;  share_hi_en_i = v.shi;
      pg0_ptr_i     = v.p0;   pg0_bank_i    = v.p0b;
      pg1_ptr_i     = v.p1;   pg1_bank_i    = v.p1b;
      addr_i        = v.addr;
      #2;
      n_chk++;
      if (xaddr_hi_o !== v.ta || bank_n_o !== v.bn || msel_o !== v.ms) begin
         n_bad++;
         $display("FAIL R%0d %s addr=%h: got ta=%h bn=%b ms=%b expected ta=%h bn=%b ms=%b",
                  v.req, tag, v.addr, xaddr_hi_o, bank_n_o, msel_o, v.ta, v.bn, v.ms);
      end
   endtask

   function automatic vec_t mk(input logic [3:0] rq, input logic cpu, input logic leg,
                               input logic alt, input logic [6:0] cfg, input logic [1:0] ssz,
                               input logic slo, input logic shi, input logic [15:0] a,
                               input logic [7:0] ta, input logic [1:0] bn, input logic [3:0] ms);
      vec_t v;
      v = '{rq, cpu, leg, alt, cfg, 1'b0, ssz, slo, shi, 8'h00, 1'b0, 8'h01, 1'b0, a, ta, bn, ms};
      return v;
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      // reset state: idle video fetch of address 0 (R1)
      #2;
      n_chk++;
      if (xaddr_hi_o !== 8'hF0 || bank_n_o !== 2'b10 || msel_o !== 4'b1011) begin
         n_bad++;
         $display("FAIL R1 reset: got ta=%h bn=%b ms=%b expected ta=f0 bn=10 ms=1011",
                  xaddr_hi_o, bank_n_o, msel_o);
      end
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) run_vec(VECS[i], "table");

      // R4 window edges
      run_vec(mk(4'd4, 1,0,0, 7'h00, 2'd0,0,0, 16'hFF04, 8'hFF, 2'b11, 4'b1011), "win_last");
      run_vec(mk(4'd4, 1,0,0, 7'h00, 2'd0,0,0, 16'hFEFF, 8'hFE, 2'b10, 4'b1000), "win_below");
      // R9 4K bottom and 8K top thresholds
      run_vec(mk(4'd9, 1,0,0, 7'h40, 2'd1,1,0, 16'h0FFF, 8'h0F, 2'b10, 4'b1011), "bot4k_in");
      run_vec(mk(4'd9, 1,0,0, 7'h40, 2'd1,1,0, 16'h1000, 8'h10, 2'b01, 4'b1011), "bot4k_out");
      run_vec(mk(4'd9, 1,0,0, 7'h70, 2'd2,0,1, 16'hDFFF, 8'hDF, 2'b01, 4'b1011), "top8k_out");
      run_vec(mk(4'd9, 1,0,0, 7'h70, 2'd2,0,1, 16'hE000, 8'hE0, 2'b10, 4'b1011), "top8k_in");
      // R5 overlay upper edge
      run_vec(mk(4'd5, 1,0,1, 7'h00, 2'd0,0,0, 16'h1000, 8'h10, 2'b10, 4'b1011), "boot_edge");
      // R1 video fetch while legacy mode is on
      run_vec(mk(4'd1, 0,1,0, 7'h00, 2'd0,0,0, 16'hABCD, 8'hFB, 2'b10, 4'b0011), "vid_legacy");
      // R10 legacy ignores sharing and the boot overlay
      run_vec(mk(4'd10, 1,1,1, 7'h40, 2'd3,1,1, 16'h0ABC, 8'h0A, 2'b01, 4'b0011), "legacy_ign");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule